// File: doc/BRIEF.md
# Shared Endpoint Route Table

This block is an associative table that turns a 16-bit endpoint identifier into the index of a switch output port. All ingress ports of a packet switch use the same table. Each ingress port has its own stream lookup channel: it offers a key on its find channel and later receives an answer on its result channel. The answer is the stored port index plus a hit flag. When several ports ask in the same cycle, a rotating arbiter serves one of them per cycle.

Mappings are installed in two ways. Each ingress port has a write strobe with an address and a data word, and an optional extra external write port exists alongside them. A write whose key is already present changes that entry in place. A write with a new key takes the next slot in insertion order. Once every slot is in use, a new key replaces the entry that was inserted earliest. Reset empties the table.

Top module: `shared_route_table`

## Requirements
- R1: After reset every entry is empty: any key looks up as a miss. With no requests pending, no ack, no find_ready and no res_valid is high.
- R2: A write stores key = cfg_addr (or ext_addr) and port = the low clog2(NUM_PORTS) bits of the data word. Upper data bits are ignored. A later lookup of that key returns res_hit=1 and that port.
- R3: A lookup of a key that is not stored returns res_hit=0. The content of res_port is then undefined.
- R4: Writing a key that is already stored replaces only its port. It uses no new slot, so no other entry is evicted.
- R5: The table holds 2^TBL_LOG2 entries in insertion order. A new key written into a full table evicts the oldest inserted key.
- R6: A write request is held high until it is acked. The ack is high only in the cycle the write is taken. In one cycle at most one write is taken, chosen by fixed priority: the lowest ingress index first, the external port last.
- R7: With EXT_CFG_EN=0 the external port is never acked and its writes do not change the table.
- R8: Lookup requests are granted one per cycle through find_ready, at most one port at a time. After port p is served, the next grant goes to the first requesting port in p+1, p+2, … (modulo NUM_PORTS). After reset the scan starts at port 0.
- R9: A result stays on res_valid/res_hit/res_port without change while its res_ready is low. During that stall no new lookup is granted. A lookup can be granted in the same cycle the pending result is consumed.
- R10: A lookup and a write taken in the same cycle see the table as it was before that write. The write is visible to lookups granted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | NUM_PORTS | Per-port write request, held until acked |
| cfg_addr | input | 16*NUM_PORTS | Per-port key to install |
| cfg_data | input | 32*NUM_PORTS | Per-port data; low bits carry the port index |
| cfg_ack | output | NUM_PORTS | Per-port write taken this cycle |
| ext_wr | input | 1 | External write request |
| ext_addr | input | 16 | External key |
| ext_data | input | 32 | External data; low bits carry the port index |
| ext_ack | output | 1 | External write taken this cycle |
| find_key | input | 16*NUM_PORTS | Per-port lookup key |
| find_valid | input | NUM_PORTS | Per-port lookup valid |
| find_ready | output | NUM_PORTS | Per-port lookup accepted |
| res_port | output | PORT_W*NUM_PORTS | Per-port resulting output port index |
| res_hit | output | NUM_PORTS | Per-port hit flag (1 = found) |
| res_valid | output | NUM_PORTS | Per-port result valid |
| res_ready | input | NUM_PORTS | Per-port result accepted |

## Verification
A config write and a lookup of the same key can both be taken in one cycle, because the write arbiter and the lookup arbiter work independently against the shared table. The bench raises a write strobe on one ingress port and a find on another port at the same falling edge. It confirms that the ack and the find_ready appear together. It then expects a miss for that lookup and a hit with the new port for the next lookup. The same pairing comes up often during the long insert-and-sweep run, where writes from all five sources are mixed with lookups under evictions and in-place updates.

// File: rtl/rtab_pkg.sv
package rtab_pkg;

    localparam int KEY_W       = 16;
    localparam int DATA_W      = 32;
    localparam int MAX_CLIENTS = 32;

    typedef logic [KEY_W-1:0] key_t;

    // One write offered to the storage array in the current cycle
    typedef struct packed {
        logic en;
        key_t key;
    } tbl_wr_t;

    // Rotating pick: first requester after 'last', scanning upward and wrapping
    function automatic int rr_pick(input logic [MAX_CLIENTS-1:0] req,
                                   input int last, input int n);
        int pick;
        pick = last;
        for (int k = MAX_CLIENTS; k >= 1; k--) begin
            if (k <= n && req[(last + k) % n]) pick = (last + k) % n;
        end
        return pick;
    endfunction

endpackage

// File: rtl/rtab_store.sv
module rtab_store
    import rtab_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6,
    parameter int PORT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  key_t              lk_key,
    output logic              lk_hit,
    output logic [PORT_W-1:0] lk_port,
    input  tbl_wr_t           wr,
    input  logic [PORT_W-1:0] wr_port
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    key_t              ent_key  [DEPTH];
    logic [PORT_W-1:0] ent_port [DEPTH];
    logic [DEPTH-1:0]  ent_vld;
    logic [DEPTH_LOG2-1:0] wptr;

    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  wr_match;
    logic              wr_hit;
    logic [DEPTH_LOG2-1:0] wr_idx;

    // Every entry compares against both keys in parallel
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign lk_match[e] = ent_vld[e] && (ent_key[e] == lk_key);
        assign wr_match[e] = ent_vld[e] && (ent_key[e] == wr.key);
    end

    always_comb begin
        lk_port = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (lk_match[e]) lk_port = lk_port | ent_port[e];
        end
    end
    assign lk_hit = |lk_match;

    always_comb begin
        wr_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (wr_match[e]) wr_idx = DEPTH_LOG2'(e);
        end
    end
    assign wr_hit = |wr_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld <= '0;
            wptr    <= '0;
        end else if (wr.en && !wr_hit) begin
            ent_vld[wptr] <= 1'b1;
            wptr          <= wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.en) begin
            if (wr_hit) begin
                ent_port[wr_idx] <= wr_port;
            end else begin
                ent_key[wptr]  <= wr.key;
                ent_port[wptr] <= wr_port;
            end
        end
    end

    // Keys stay unique, so a lookup never matches two slots (R4)
    p_unique_match_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(lk_match) <= 1);

endmodule

// File: rtl/rtab_cfg_arb.sv
module rtab_cfg_arb
    import rtab_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int PORT_W     = 3,
    parameter bit EXT_CFG_EN = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        cfg_wr,
    input  logic [KEY_W*NUM_PORTS-1:0]  cfg_addr,
    input  logic [DATA_W*NUM_PORTS-1:0] cfg_data,
    output logic [NUM_PORTS-1:0]        cfg_ack,
    input  logic                        ext_wr,
    input  key_t                        ext_addr,
    input  logic [DATA_W-1:0]           ext_data,
    output logic                        ext_ack,
    output tbl_wr_t                     wr,
    output logic [PORT_W-1:0]           wr_port
);
    localparam int NSRC = NUM_PORTS + 1;

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] gnt;
    int              sel;
    logic            unused_hi;

    assign req = {ext_wr && EXT_CFG_EN, cfg_wr};

    // Lowest index wins; the external source sits at the top index
    always_comb begin
        sel = NUM_PORTS;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (req[s]) sel = s;
        end
        gnt = '0;
        if (|req) gnt[sel] = 1'b1;
    end

    always_comb begin
        wr.en   = |req;
        wr.key  = ext_addr;
        wr_port = ext_data[PORT_W-1:0];
        if (sel < NUM_PORTS) begin
            wr.key  = cfg_addr[sel*KEY_W +: KEY_W];
            wr_port = cfg_data[sel*DATA_W +: PORT_W];
        end
    end

    assign cfg_ack = gnt[NUM_PORTS-1:0];
    assign ext_ack = gnt[NUM_PORTS];

    // Data bits above the port field carry nothing for this table
    always_comb begin
        unused_hi = ^ext_data[DATA_W-1:PORT_W];
        for (int i = 0; i < NUM_PORTS; i++) begin
            unused_hi = unused_hi ^ (^cfg_data[i*DATA_W+PORT_W +: DATA_W-PORT_W]);
        end
    end

    p_single_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_ack, cfg_ack}));

    p_ack_has_req_r6: assert property (@(posedge clk) disable iff (rst)
        ((cfg_ack & ~cfg_wr) == '0) && !(ext_ack && !ext_wr));

endmodule

// File: rtl/rtab_lookup_arb.sv
module rtab_lookup_arb
    import rtab_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [KEY_W*NUM_PORTS-1:0]  find_key,
    input  logic [NUM_PORTS-1:0]        find_valid,
    output logic [NUM_PORTS-1:0]        find_ready,
    output logic [PORT_W*NUM_PORTS-1:0] res_port,
    output logic [NUM_PORTS-1:0]        res_hit,
    output logic [NUM_PORTS-1:0]        res_valid,
    input  logic [NUM_PORTS-1:0]        res_ready,
    output key_t                        lk_key,
    input  logic                        lk_hit,
    input  logic [PORT_W-1:0]           lk_port
);
    localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic             rv;
    logic [SEL_W-1:0] rsel;
    logic             rhit;
    logic [PORT_W-1:0] rport;
    logic [SEL_W-1:0] last;
    logic [SEL_W-1:0] pick;
    logic             can_take;
    logic             take;

    assign pick     = SEL_W'(rr_pick(MAX_CLIENTS'(find_valid), int'(last), NUM_PORTS));
    assign can_take = !rv || res_ready[rsel];
    assign take     = can_take && (|find_valid);
    assign lk_key   = find_key[int'(pick)*KEY_W +: KEY_W];

    always_comb begin
        find_ready = '0;
        if (take) find_ready[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rv   <= 1'b0;
            rsel <= '0;
            last <= SEL_W'(NUM_PORTS - 1);
        end else if (take) begin
            rv   <= 1'b1;
            rsel <= pick;
            last <= pick;
        end else if (rv && res_ready[rsel]) begin
            rv <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            rhit  <= lk_hit;
            rport <= lk_port;
        end
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_res
        assign res_valid[i]                  = rv && (rsel == SEL_W'(i));
        assign res_hit[i]                    = rhit;
        assign res_port[i*PORT_W +: PORT_W]  = rport;
    end

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(find_ready));

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (|(res_valid & ~res_ready)) |=>
            $stable(res_valid) && $stable(res_hit) && $stable(res_port));

    p_no_take_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (|(res_valid & ~res_ready)) |-> (find_ready == '0));

endmodule

// File: rtl/shared_route_table.sv
module shared_route_table
    import rtab_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int TBL_LOG2   = 6,
    parameter bit EXT_CFG_EN = 1'b1,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        cfg_wr,
    input  logic [16*NUM_PORTS-1:0]     cfg_addr,
    input  logic [32*NUM_PORTS-1:0]     cfg_data,
    output logic [NUM_PORTS-1:0]        cfg_ack,
    input  logic                        ext_wr,
    input  logic [15:0]                 ext_addr,
    input  logic [31:0]                 ext_data,
    output logic                        ext_ack,
    input  logic [16*NUM_PORTS-1:0]     find_key,
    input  logic [NUM_PORTS-1:0]        find_valid,
    output logic [NUM_PORTS-1:0]        find_ready,
    output logic [PORT_W*NUM_PORTS-1:0] res_port,
    output logic [NUM_PORTS-1:0]        res_hit,
    output logic [NUM_PORTS-1:0]        res_valid,
    input  logic [NUM_PORTS-1:0]        res_ready
);
    tbl_wr_t           wr;
    logic [PORT_W-1:0] wr_port;
    key_t              lk_key;
    logic              lk_hit;
    logic [PORT_W-1:0] lk_port;

    rtab_cfg_arb #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .EXT_CFG_EN(EXT_CFG_EN)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_addr(cfg_addr),
        .cfg_data(cfg_data),
        .cfg_ack (cfg_ack),
        .ext_wr  (ext_wr),
        .ext_addr(ext_addr),
        .ext_data(ext_data),
        .ext_ack (ext_ack),
        .wr      (wr),
        .wr_port (wr_port)
    );

    rtab_store #(
        .DEPTH_LOG2(TBL_LOG2),
        .PORT_W    (PORT_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .lk_key (lk_key),
        .lk_hit (lk_hit),
        .lk_port(lk_port),
        .wr     (wr),
        .wr_port(wr_port)
    );

    rtab_lookup_arb #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W)
    ) u_lookup (
        .clk       (clk),
        .rst       (rst),
        .find_key  (find_key),
        .find_valid(find_valid),
        .find_ready(find_ready),
        .res_port  (res_port),
        .res_hit   (res_hit),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .lk_key    (lk_key),
        .lk_hit    (lk_hit),
        .lk_port   (lk_port)
    );

endmodule

// File: tb/shared_route_table_tb.sv
`timescale 1ns/1ps
module shared_route_table_tb;

    localparam int N     = 4;
    localparam int PW    = 2;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]      cfg_wr = '0;
    logic [16*N-1:0]   cfg_addr = '0;
    logic [32*N-1:0]   cfg_data = '0;
    logic [N-1:0]      cfg_ack;
    logic              ext_wr = 1'b0;
    logic [15:0]       ext_addr = '0;
    logic [31:0]       ext_data = '0;
    logic              ext_ack;
    logic [16*N-1:0]   find_key = '0;
    logic [N-1:0]      find_valid = '0;
    logic [N-1:0]      find_ready;
    logic [PW*N-1:0]   res_port;
    logic [N-1:0]      res_hit;
    logic [N-1:0]      res_valid;
    logic [N-1:0]      res_ready = '1;

    // Second copy without the external write port
    logic              n_ext_wr = 1'b0;
    logic              n_ext_ack;
    logic [N-1:0]      n_cfg_ack;
    logic [16*N-1:0]   n_find_key = '0;
    logic [N-1:0]      n_find_valid = '0;
    logic [N-1:0]      n_find_ready;
    logic [PW*N-1:0]   n_res_port;
    logic [N-1:0]      n_res_hit;
    logic [N-1:0]      n_res_valid;

    shared_route_table #(.NUM_PORTS(N), .TBL_LOG2(3), .EXT_CFG_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_ack(cfg_ack),
        .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_data(ext_data), .ext_ack(ext_ack),
        .find_key(find_key), .find_valid(find_valid), .find_ready(find_ready),
        .res_port(res_port), .res_hit(res_hit), .res_valid(res_valid), .res_ready(res_ready)
    );

    shared_route_table #(.NUM_PORTS(N), .TBL_LOG2(3), .EXT_CFG_EN(1'b0)) u_dut_noext (
        .clk(clk), .rst(rst),
        .cfg_wr('0), .cfg_addr('0), .cfg_data('0), .cfg_ack(n_cfg_ack),
        .ext_wr(n_ext_wr), .ext_addr(16'h0077), .ext_data(32'h1), .ext_ack(n_ext_ack),
        .find_key(n_find_key), .find_valid(n_find_valid), .find_ready(n_find_ready),
        .res_port(n_res_port), .res_hit(n_res_hit), .res_valid(n_res_valid), .res_ready('1)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    // Reference table: insertion-ordered slots
    logic [15:0] mkey [DEPTH];
    logic [1:0]  mport[DEPTH];
    bit          mvld [DEPTH];
    int          mptr;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int e = 0; e < DEPTH; e++) mvld[e] = 0;
        mptr = 0;
    endtask

    task automatic model_write(input logic [15:0] k, input logic [1:0] p);
        bit found = 0;
        for (int e = 0; e < DEPTH; e++) begin
            if (mvld[e] && mkey[e] == k) begin mport[e] = p; found = 1; end
        end
        if (!found) begin
            mkey[mptr] = k; mport[mptr] = p; mvld[mptr] = 1;
            mptr = (mptr + 1) % DEPTH;
        end
    endtask

    task automatic model_find(input logic [15:0] k, output bit h, output logic [1:0] p);
        h = 0; p = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (mvld[e] && mkey[e] == k) begin h = 1; p = mport[e]; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = '0; ext_wr = 1'b0; find_valid = '0; res_ready = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    function automatic bit acked(input int s);
        return (s == N) ? ext_ack : cfg_ack[s];
    endfunction

    // Source s in 0..N-1 is an ingress port, s == N is the external port
    task automatic do_write(input int s, input logic [15:0] k, input logic [1:0] p);
        logic [31:0] d;
        d = {30'(k * 7 + 3), p};
        @(negedge clk);
        if (s == N) begin ext_wr = 1'b1; ext_addr = k; ext_data = d; end
        else begin cfg_wr[s] = 1'b1; cfg_addr[s*16 +: 16] = k; cfg_data[s*32 +: 32] = d; end
        #1;
        while (!acked(s)) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        if (s == N) ext_wr = 1'b0; else cfg_wr[s] = 1'b0;
        model_write(k, p);
    endtask

    task automatic do_lookup(input int s, input logic [15:0] k,
                             output bit h, output logic [1:0] p);
        @(negedge clk);
        find_valid[s] = 1'b1; find_key[s*16 +: 16] = k;
        #1;
        while (!find_ready[s]) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        find_valid[s] = 1'b0;
        @(negedge clk);
        check(res_valid[s] == 1'b1, "R9 result valid", res_valid, 1 << s);
        h = res_hit[s];
        p = res_port[s*PW +: PW];
    endtask

    task automatic verify_key(input int s, input logic [15:0] k, input string tag);
        bit h, eh;
        logic [1:0] p, ep;
        model_find(k, eh, ep);
        do_lookup(s, k, h, p);
        check(h == eh, eh ? tag : "R5 evicted/absent key", h, eh);
        if (eh) check(p == ep, tag, p, ep);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit h;
        logic [1:0] p;
        int prev;
        logic [PW-1:0] held_port;
        logic [N-1:0]  held_hit;
        logic [15:0]   keys [20];
        bit            upd  [20];

        do_reset();

        // R1: quiet outputs and empty table
        @(negedge clk);
        check(res_valid == '0, "R1 res_valid", res_valid, 0);
        check({ext_ack, cfg_ack} == '0, "R1 ack", {ext_ack, cfg_ack}, 0);
        check(find_ready == '0, "R1 find_ready", find_ready, 0);
        do_lookup(0, 16'h0000, h, p);
        check(h == 1'b0, "R1 key 0 miss", h, 0);
        do_lookup(3, 16'hFFFF, h, p);
        check(h == 1'b0, "R1 key FFFF miss", h, 0);

        // R6: all five sources request together
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            cfg_wr[i] = 1'b1;
            cfg_addr[i*16 +: 16] = 16'h0300 + 16'(i);
            cfg_data[i*32 +: 32] = {30'h2AAA_AAAA, 2'(3 - i)};
        end
        ext_wr = 1'b1; ext_addr = 16'h03FF; ext_data = {30'h1555_5555, 2'd1};
        for (int s = 0; s <= N; s++) begin
            #1;
            check({ext_ack, cfg_ack} == 5'(1 << s), "R6 priority order", {ext_ack, cfg_ack}, 1 << s);
            @(posedge clk); #1;
            if (s == N) ext_wr = 1'b0; else cfg_wr[s] = 1'b0;
            @(negedge clk);
        end
        #1;
        check({ext_ack, cfg_ack} == '0, "R6 ack drops", {ext_ack, cfg_ack}, 0);
        for (int i = 0; i < N; i++) model_write(16'h0300 + 16'(i), 2'(3 - i));
        model_write(16'h03FF, 2'd1);
        for (int i = 0; i < N; i++) verify_key((i + 1) % N, 16'h0300 + 16'(i), "R2 stored port");
        verify_key(2, 16'h03FF, "R2 external write");
        verify_key(1, 16'h0444, "R3 unknown key");

        // R10: write and lookup of the same key taken in one cycle
        do_reset();
        @(negedge clk);
        cfg_wr[0] = 1'b1; cfg_addr[15:0] = 16'h0055; cfg_data[31:0] = 32'hFFFF_FFF2;
        find_valid[1] = 1'b1; find_key[31:16] = 16'h0055;
        #1;
        check(cfg_ack[0] && find_ready[1], "R10 same-cycle accept", {cfg_ack[0], find_ready[1]}, 3);
        @(posedge clk); #1;
        cfg_wr[0] = 1'b0; find_valid[1] = 1'b0;
        @(negedge clk);
        check(res_valid[1] && !res_hit[1], "R10 old contents seen", {res_valid[1], res_hit[1]}, 2);
        model_write(16'h0055, 2'd2);
        verify_key(1, 16'h0055, "R10 write visible next");

        // R8: rotating grants, all ports then a sparse set
        do_reset();
        @(negedge clk);
        find_valid = '1;
        prev = N - 1;
        for (int c = 0; c < 14; c++) begin
            int exp;
            if (c == 8) find_valid = 4'b1010;
            exp = prev;
            for (int k = N; k >= 1; k--) if (find_valid[(prev + k) % N]) exp = (prev + k) % N;
            #1;
            check(find_ready == 4'(1 << exp), "R8 rotation", find_ready, 1 << exp);
            prev = exp;
            @(posedge clk);
            @(negedge clk);
        end
        find_valid = '0;
        repeat (2) @(negedge clk);

        // R9: stalled result blocks new grants and stays stable
        res_ready[2] = 1'b0;
        find_valid[2] = 1'b1; find_key[47:32] = 16'h0055;
        #1;
        while (!find_ready[2]) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        find_valid[2] = 1'b0;
        find_valid[0] = 1'b1; find_valid[1] = 1'b1;
        @(negedge clk);
        held_port = res_port[2*PW +: PW];
        held_hit  = res_hit;
        for (int c = 0; c < 3; c++) begin
            check(res_valid == 4'b0100, "R9 result held", res_valid, 4'b0100);
            check(find_ready == '0, "R9 no grant in stall", find_ready, 0);
            check(res_port[2*PW +: PW] == held_port && res_hit == held_hit,
                  "R9 stable payload", res_port[2*PW +: PW], held_port);
            @(negedge clk);
        end
        res_ready[2] = 1'b1;
        #1;
        check(find_ready != '0, "R9 grant while draining", find_ready, 1);
        @(posedge clk); #1;
        find_valid = '0;
        repeat (4) @(negedge clk);

        // R4/R5: insert sweep with in-place updates and evictions
        do_reset();
        for (int i = 0; i < 20; i++) begin
            keys[i] = 16'h1000 + 16'(i * 16'h0113);
            upd[i]  = 0;
            do_write(i % (N + 1), keys[i], 2'(i % N));
            if (i % 3 == 2) begin
                do_write((i + 2) % (N + 1), keys[i-1], 2'((i + 1) % N));
                upd[i-1] = 1;
            end
            for (int j = 0; j <= i; j++)
                verify_key(j % N, keys[j], upd[j] ? "R4 updated in place" : "R2 stored port");
        end

        // R7: external port disabled
        @(negedge clk);
        n_ext_wr = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            check(n_ext_ack == 1'b0, "R7 no external ack", n_ext_ack, 0);
            @(negedge clk);
        end
        n_ext_wr = 1'b0;
        n_find_valid[0] = 1'b1; n_find_key[15:0] = 16'h0077;
        #1;
        while (!n_find_ready[0]) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        n_find_valid[0] = 1'b0;
        @(negedge clk);
        check(n_res_valid[0] && !n_res_hit[0], "R7 write had no effect",
              {n_res_valid[0], n_res_hit[0]}, 2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule